// File: doc/BRIEF.md
# Column-Associative Cache Controller

This block is a two-way cache built from a single direct-mapped array of lines. Each block address has two candidate lines. The home line is picked by the low address bits. The partner line is the home index with its top bit inverted. A lookup always probes the home line first. A second probe is made of the partner line one cycle later, but only when the home line could not rule it out. Each line is treated as one wide data word. Each line carries a valid flag, a tag, the data and a rehash flag. The rehash flag marks a block that sits in its partner position rather than its home position.

The processor side is a read-only request/response handshake with one request outstanding at a time. A block found on the second probe is exchanged with the home line, so that it is reached in one probe next time. Misses fetch the block from lower-level memory over a request/response port. The fetched block always lands in the home line.

Top module: `column_assoc_cache`

## Requirements
- R1: After reset every line is invalid with its rehash flag clear; `req_ready` is 1 and `rsp_valid` and `mem_req_valid` are 0.
- R2: Every response returns on `rsp_data` the memory word of the requested block address. `rsp_kind` is 2'b01 (home hit), 2'b10 (partner hit) or 2'b11 (miss) while `rsp_valid` is 1, and 2'b00 otherwise.
- R3: A home-line hit responds with kind 2'b01 in the cycle after the request is accepted. It changes no line.
- R4: A home-line miss whose home rehash flag is clear probes the partner line. On a match it responds with kind 2'b10 two cycles after acceptance. It then holds `req_ready` low for one cycle while the two lines exchange contents, after which the block's home line holds it with rehash clear and the partner holds the former home block with rehash set.
- R5: A home-line miss whose home rehash flag is set skips the partner probe. `mem_req_valid` rises in the second cycle after acceptance, and the response (kind 2'b11) comes D cycles after acceptance plus one, where D is the memory latency. The fetched block replaces the home line and the partner line is left unchanged.
- R6: When both probes miss, the response (kind 2'b11) comes D cycles after acceptance plus two. The former home block moves to the partner line with rehash set, the fetched block fills the home line with rehash clear, and the former partner block is discarded.
- R7: The partner index is the home index with its most significant bit inverted (with 8 lines, 2 pairs with 6). The stored tag is every address bit from the top index bit upward, so either line of a pair can hold either mapping.
- R8: From the accepting clock edge until the response has been given (and through the exchange cycle of R4), `req_ready` stays 0.
- R9: `mem_req_addr` equals the requested block address and `mem_req_valid` stays 1 until the cycle in which `mem_rsp_valid` is 1. `mem_rsp_valid` is only given while `mem_req_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_addr | input | ADDR_W | Block address of the request |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_kind | output | 2 | 01 home hit, 10 partner hit, 11 miss, 00 idle |
| rsp_data | output | DATA_W | Block data of the response |
| mem_req_valid | output | 1 | Fetch request to lower memory |
| mem_req_addr | output | ADDR_W | Block address to fetch |
| mem_rsp_valid | input | 1 | Fetched block present |
| mem_rsp_data | input | DATA_W | Fetched block data |

## Verification
The hardest case to reach from the ports is the skipped probe. It needs a home line that already holds a displaced block with its rehash flag set, and then a request whose home index is that line while its tag matches neither line of the pair. The stimulus builds this on purpose: two conflicting blocks are loaded into one home index so that the first is pushed to the partner, and then a third address whose home index is that partner line is requested. Long runs confined to a single pair of lines then cover the exchange and discard paths over and over, each outcome being predicted by a line-level model in the bench.

// File: rtl/ca_pkg.sv
package ca_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PROBE1 = 3'd1,
    ST_PROBE2 = 3'd2,
    ST_SWAP   = 3'd3,
    ST_FETCH  = 3'd4
  } ca_state_e;

  localparam logic [1:0] KIND_NONE   = 2'b00;
  localparam logic [1:0] KIND_HOME   = 2'b01;
  localparam logic [1:0] KIND_PARTNR = 2'b10;
  localparam logic [1:0] KIND_MISS   = 2'b11;
endpackage

// File: rtl/ca_line_store.sv
module ca_line_store #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  p_idx,
  input  logic [IDX_W-1:0]  q_idx,
  output logic              p_valid,
  output logic              p_rehash,
  output logic [TAG_W-1:0]  p_tag,
  output logic [DATA_W-1:0] p_data,
  output logic              q_valid,
  output logic              q_rehash,
  output logic [TAG_W-1:0]  q_tag,
  output logic [DATA_W-1:0] q_data,
  input  logic              wr_p_en,
  input  logic              wr_p_valid,
  input  logic              wr_p_rehash,
  input  logic [TAG_W-1:0]  wr_p_tag,
  input  logic [DATA_W-1:0] wr_p_data,
  input  logic              wr_q_en,
  input  logic              wr_q_valid,
  input  logic              wr_q_rehash,
  input  logic [TAG_W-1:0]  wr_q_tag,
  input  logic [DATA_W-1:0] wr_q_data
);
  localparam int NUM_LINES = 1 << IDX_W;

  logic [NUM_LINES-1:0] valid_vec;
  logic [NUM_LINES-1:0] rehash_vec;
  logic [TAG_W-1:0]     tag_arr  [NUM_LINES];
  logic [DATA_W-1:0]    data_arr [NUM_LINES];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam logic [IDX_W-1:0] LINE_ID = IDX_W'(i);
    logic              v_q;
    logic              r_q;
    logic [TAG_W-1:0]  t_q;
    logic [DATA_W-1:0] d_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        r_q <= 1'b0;
        t_q <= '0;
        d_q <= '0;
      end else if (wr_p_en && (p_idx == LINE_ID)) begin
        v_q <= wr_p_valid;
        r_q <= wr_p_rehash;
        t_q <= wr_p_tag;
        d_q <= wr_p_data;
      end else if (wr_q_en && (q_idx == LINE_ID)) begin
        v_q <= wr_q_valid;
        r_q <= wr_q_rehash;
        t_q <= wr_q_tag;
        d_q <= wr_q_data;
      end
    end

    assign valid_vec[i]  = v_q;
    assign rehash_vec[i] = r_q;
    assign tag_arr[i]    = t_q;
    assign data_arr[i]   = d_q;
  end

  assign p_valid  = valid_vec[p_idx];
  assign p_rehash = rehash_vec[p_idx];
  assign p_tag    = tag_arr[p_idx];
  assign p_data   = data_arr[p_idx];
  assign q_valid  = valid_vec[q_idx];
  assign q_rehash = rehash_vec[q_idx];
  assign q_tag    = tag_arr[q_idx];
  assign q_data   = data_arr[q_idx];
endmodule

// File: rtl/ca_ctrl.sv
module ca_ctrl
  import ca_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 16,
  localparam int TAG_W = ADDR_W - IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic [IDX_W-1:0]  p_idx,
  output logic [IDX_W-1:0]  q_idx,
  input  logic              p_valid,
  input  logic              p_rehash,
  input  logic [TAG_W-1:0]  p_tag,
  input  logic [DATA_W-1:0] p_data,
  input  logic              q_valid,
  input  logic              q_rehash,
  input  logic [TAG_W-1:0]  q_tag,
  input  logic [DATA_W-1:0] q_data,
  output logic              wr_p_en,
  output logic              wr_p_valid,
  output logic              wr_p_rehash,
  output logic [TAG_W-1:0]  wr_p_tag,
  output logic [DATA_W-1:0] wr_p_data,
  output logic              wr_q_en,
  output logic              wr_q_valid,
  output logic              wr_q_rehash,
  output logic [TAG_W-1:0]  wr_q_tag,
  output logic [DATA_W-1:0] wr_q_data,
  output logic              probe1_hit,
  output logic              probe2_hit,
  output logic              early_miss,
  output logic              late_miss,
  output logic              fill_done,
  output logic              swap_go
);
  localparam logic [IDX_W-1:0] TOP_MASK = IDX_W'(1) << (IDX_W - 1);

  // R7: home index, partner index and stored tag
  function automatic logic [IDX_W-1:0] home_index(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [IDX_W-1:0] partner_index(input logic [IDX_W-1:0] i);
    return i ^ TOP_MASK;
  endfunction

  function automatic logic [TAG_W-1:0] line_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W-1];
  endfunction

  ca_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              skip_q;
  logic [TAG_W-1:0]  want_tag;
  logic              p_match, q_match;
  logic              accept;

  assign accept   = req_valid && req_ready;
  assign p_idx    = home_index(addr_q);
  assign q_idx    = partner_index(p_idx);
  assign want_tag = line_tag(addr_q);
  assign p_match  = p_valid && (p_tag == want_tag);
  assign q_match  = q_valid && (q_tag == want_tag);

  assign probe1_hit = (state_q == ST_PROBE1) && p_match;
  assign early_miss = (state_q == ST_PROBE1) && !p_match && p_rehash;
  assign probe2_hit = (state_q == ST_PROBE2) && q_match;
  assign late_miss  = (state_q == ST_PROBE2) && !q_match;
  assign fill_done  = (state_q == ST_FETCH) && mem_rsp_valid;
  assign swap_go    = (state_q == ST_SWAP);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept) state_d = ST_PROBE1;
      ST_PROBE1: begin
        if (probe1_hit)      state_d = ST_IDLE;
        else if (early_miss) state_d = ST_FETCH;
        else                 state_d = ST_PROBE2;
      end
      ST_PROBE2: state_d = probe2_hit ? ST_SWAP : ST_FETCH;
      ST_SWAP:   state_d = ST_IDLE;
      ST_FETCH:  if (fill_done) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      skip_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q <= req_addr;
        skip_q <= 1'b0;
      end else if (early_miss) begin
        skip_q <= 1'b1;
      end
    end
  end

  // Line updates: exchange on partner hit, fill (with optional displacement) on miss
  always_comb begin
    wr_p_en     = 1'b0;
    wr_p_valid  = 1'b0;
    wr_p_rehash = 1'b0;
    wr_p_tag    = want_tag;
    wr_p_data   = mem_rsp_data;
    wr_q_en     = 1'b0;
    wr_q_valid  = p_valid;
    wr_q_rehash = 1'b1;
    wr_q_tag    = p_tag;
    wr_q_data   = p_data;
    if (swap_go) begin
      wr_p_en    = 1'b1;
      wr_p_valid = q_valid;
      wr_p_tag   = q_tag;
      wr_p_data  = q_data;
      wr_q_en    = 1'b1;
    end else if (fill_done) begin
      wr_p_en    = 1'b1;
      wr_p_valid = 1'b1;
      wr_q_en    = !skip_q;
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_FETCH);
  assign mem_req_addr  = addr_q;
  assign rsp_valid     = probe1_hit || probe2_hit || fill_done;

  always_comb begin
    rsp_kind = KIND_NONE;
    rsp_data = mem_rsp_data;
    if (probe1_hit) begin
      rsp_kind = KIND_HOME;
      rsp_data = p_data;
    end else if (probe2_hit) begin
      rsp_kind = KIND_PARTNR;
      rsp_data = q_data;
    end else if (fill_done) begin
      rsp_kind = KIND_MISS;
    end
  end

  logic unused_q_rehash;
  assign unused_q_rehash = q_rehash;
endmodule

// File: rtl/column_assoc_cache.sv
module column_assoc_cache #(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  localparam int TAG_W = ADDR_W - IDX_W + 1;

  logic [IDX_W-1:0]  p_idx, q_idx;
  logic              p_valid, p_rehash, q_valid, q_rehash;
  logic [TAG_W-1:0]  p_tag, q_tag;
  logic [DATA_W-1:0] p_data, q_data;
  logic              wr_p_en, wr_p_valid, wr_p_rehash;
  logic [TAG_W-1:0]  wr_p_tag;
  logic [DATA_W-1:0] wr_p_data;
  logic              wr_q_en, wr_q_valid, wr_q_rehash;
  logic [TAG_W-1:0]  wr_q_tag;
  logic [DATA_W-1:0] wr_q_data;

  // Named internal events for the checker
  logic probe1_hit, probe2_hit, early_miss, late_miss, fill_done, swap_go;

  ca_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .p_idx(p_idx), .q_idx(q_idx),
    .p_valid(p_valid), .p_rehash(p_rehash), .p_tag(p_tag), .p_data(p_data),
    .q_valid(q_valid), .q_rehash(q_rehash), .q_tag(q_tag), .q_data(q_data),
    .wr_p_en(wr_p_en), .wr_p_valid(wr_p_valid), .wr_p_rehash(wr_p_rehash),
    .wr_p_tag(wr_p_tag), .wr_p_data(wr_p_data),
    .wr_q_en(wr_q_en), .wr_q_valid(wr_q_valid), .wr_q_rehash(wr_q_rehash),
    .wr_q_tag(wr_q_tag), .wr_q_data(wr_q_data)
  );

  ca_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .p_idx(p_idx), .q_idx(q_idx),
    .p_valid(p_valid), .p_rehash(p_rehash), .p_tag(p_tag), .p_data(p_data),
    .q_valid(q_valid), .q_rehash(q_rehash), .q_tag(q_tag), .q_data(q_data),
    .wr_p_en(wr_p_en), .wr_p_valid(wr_p_valid), .wr_p_rehash(wr_p_rehash),
    .wr_p_tag(wr_p_tag), .wr_p_data(wr_p_data),
    .wr_q_en(wr_q_en), .wr_q_valid(wr_q_valid), .wr_q_rehash(wr_q_rehash),
    .wr_q_tag(wr_q_tag), .wr_q_data(wr_q_data),
    .probe1_hit(probe1_hit), .probe2_hit(probe2_hit), .early_miss(early_miss),
    .late_miss(late_miss), .fill_done(fill_done), .swap_go(swap_go)
  );
endmodule

// File: rtl/ca_checker.sv
module ca_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic [1:0] rsp_kind,
  input logic       mem_req_valid,
  input logic       mem_rsp_valid,
  input logic       probe1_hit,
  input logic       probe2_hit,
  input logic       early_miss,
  input logic       late_miss,
  input logic       fill_done,
  input logic       swap_go
);
  assert_kind_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_kind != 2'b00));

  assert_kind_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_kind == 2'b00));

  assert_home_hit_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == 2'b01) |-> $past(req_valid && req_ready));

  assert_partner_then_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    probe2_hit |=> (swap_go && !req_ready && !rsp_valid));

  assert_skip_to_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    early_miss |=> (mem_req_valid && !rsp_valid));

  assert_double_miss_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    late_miss |=> mem_req_valid);

  assert_one_outstanding_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_busy_while_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  assert_fetch_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_rsp_valid) |=> mem_req_valid);

  assert_fill_only_when_fetching_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |-> mem_req_valid);

  assert_events_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({probe1_hit, probe2_hit, early_miss, late_miss, fill_done, swap_go}));
endmodule

bind column_assoc_cache ca_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .mem_req_valid(mem_req_valid),
  .mem_rsp_valid(mem_rsp_valid), .probe1_hit(probe1_hit), .probe2_hit(probe2_hit),
  .early_miss(early_miss), .late_miss(late_miss), .fill_done(fill_done),
  .swap_go(swap_go)
);

// File: tb/column_assoc_cache_tb.sv
module column_assoc_cache_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 6;
  localparam int IDX_W      = 3;
  localparam int DATA_W     = 16;
  localparam int LINES      = 1 << IDX_W;
  localparam int MEM_DLY    = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              rsp_valid;
  logic [1:0]        rsp_kind;
  logic [DATA_W-1:0] rsp_data;
  logic              mem_req_valid;
  logic [ADDR_W-1:0] mem_req_addr;
  logic              mem_rsp_valid = 1'b0;
  logic [DATA_W-1:0] mem_rsp_data = '0;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  column_assoc_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
    .rsp_data(rsp_data), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
    return DATA_W'(16'hA000 ^ (int'(a) * 61));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Lower memory model: answers after MEM_DLY sampled cycles of request
  logic [ADDR_W-1:0] cur_addr = '0;
  int mem_cnt = 0;
  always @(negedge clk) begin
    if (mem_req_valid) begin
      mem_cnt = mem_cnt + 1;
      if (mem_cnt == MEM_DLY) begin
        chk(mem_req_addr == cur_addr, "R9 fetch address", int'(mem_req_addr), int'(cur_addr));
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_word(mem_req_addr);
      end else begin
        mem_rsp_valid = 1'b0;
      end
    end else begin
      mem_cnt = 0;
      mem_rsp_valid = 1'b0;
    end
  end

  // Line-level model built from the requirements
  bit                mv [LINES];
  bit                mr [LINES];
  logic [ADDR_W-1:0] ma [LINES];

  task automatic access(input logic [ADDR_W-1:0] a);
    logic [IDX_W-1:0] p, q;
    int ekind, elat, lat;
    bit got, busy_ok;
    string rq;
    bit tv;
    logic [ADDR_W-1:0] ta;
    p = a[IDX_W-1:0];
    q = p ^ IDX_W'(LINES / 2);   // R7 partner index
    if (mv[p] && ma[p] == a)      begin ekind = 1; elat = 1;           rq = "R3"; end
    else if (mr[p])               begin ekind = 3; elat = 1 + MEM_DLY; rq = "R5"; end
    else if (mv[q] && ma[q] == a) begin ekind = 2; elat = 2;           rq = "R4"; end
    else                          begin ekind = 3; elat = 2 + MEM_DLY; rq = "R6"; end

    @(negedge clk);
    while (!req_ready) @(negedge clk);
    #1;
    req_valid = 1'b1;
    req_addr  = a;
    cur_addr  = a;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    lat = 0; got = 1'b0; busy_ok = 1'b1;
    while (!got && lat < 40) begin
      @(negedge clk);
      #1;
      lat++;
      if (rsp_valid) got = 1'b1;
      else if (req_ready) busy_ok = 1'b0;
    end
    chk(got && int'(rsp_kind) == ekind, {rq, " kind"}, int'(rsp_kind), ekind);
    chk(lat == elat, {rq, " latency"}, lat, elat);
    chk(rsp_data == mem_word(a), "R2 data", int'(rsp_data), int'(mem_word(a)));
    chk(busy_ok, "R8 ready low while busy", int'(busy_ok), 1);
    if (ekind == 2) begin
      @(negedge clk);
      #1;
      chk(!req_ready, "R4 ready low during exchange", int'(req_ready), 0);
    end

    case (rq)
      "R5": begin mv[p] = 1; ma[p] = a; mr[p] = 0; end
      "R4": begin
        tv = mv[p]; ta = ma[p];
        mv[p] = mv[q]; ma[p] = ma[q]; mr[p] = 0;
        mv[q] = tv;    ma[q] = ta;    mr[q] = 1;
      end
      "R6": begin
        mv[q] = mv[p]; ma[q] = ma[p]; mr[q] = 1;
        mv[p] = 1;     ma[p] = a;     mr[p] = 0;
      end
      default: ;
    endcase
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    for (int i = 0; i < LINES; i++) begin mv[i] = 0; mr[i] = 0; ma[i] = '0; end
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1 reset outputs",
        int'({req_ready, rsp_valid, mem_req_valid}), 4);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1 idle after reset",
        int'({req_ready, rsp_valid, mem_req_valid}), 4);

    // Directed: build a displaced block then force each outcome
    access(6'd2);   // R6 cold miss at home 2
    access(6'd10);  // R6 same home 2: block 2 moves to line 6 with rehash (R7 pairing)
    access(6'd2);   // R4 partner hit, exchange
    access(6'd2);   // R3 home hit after exchange
    access(6'd6);   // R5 home 6 holds a rehashed block: probe skipped
    access(6'd2);   // R3 home line 2 unaffected by skip
    access(6'd10);  // R6 block 10 was discarded when 6 filled line 6? no: line 6 replaced, 10 lost

    // Sweep every address twice in two orders
    for (int r = 0; r < 2; r++)
      for (int i = 0; i < (1 << ADDR_W); i++)
        access(ADDR_W'(r == 0 ? i : (1 << ADDR_W) - 1 - i));

    // Conflict-heavy runs on one pair of lines, then on the full range
    lfsr = 8'h5b;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (i < 400) access({lfsr[5:3], lfsr[0], 2'b10});
      else         access(lfsr[5:0]);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule